// File: doc/BRIEF.md
# Protected segment address translator

The translator maps a logical memory access onto a 24-bit physical address. An access is given as a segment slot number, a 16-bit offset and an access kind. The kind is a data read, a data write or an instruction fetch. Each segment slot holds a cached descriptor. The descriptor has a 24-bit base, a 16-bit limit and an 8-bit rights byte, and it is loaded through a separate write port.

Before the access is allowed, the block checks three things: that the segment is present, that its type allows this kind of access, and that the offset lies within the limit. An allowed access gives a one-cycle go strobe together with the physical address. A refused access suppresses the strobe and reports a fault code. Privilege comparison and the fetch of descriptors from memory are handled elsewhere.

Top module: `seg_xlat`

## Requirements
- R1: For an allowed access, paddr_o equals (base + zero-extended offset) modulo 2^24. For a refused access, and whenever valid_o is low, paddr_o is 0.
- R2: The results (valid_o, go_o, fault_o, paddr_o) are registered and appear one clock after the cycle in which req_valid_i was high. After reset, and in any cycle that follows no request, valid_o, go_o and fault_o are all 0.
- R3: If rights bit 7 (present) is 0, fault_o is 1 (not present) and go_o stays low, whatever the other bits and the offset are.
- R4: If the segment is present and its type allows the access, an offset greater than the limit gives fault_o = 2 (limit). An offset equal to the limit is allowed.
- R5: If rights bit 4 (code/data descriptor) is 0, every access gives fault_o = 3 (type).
- R6: If rights bit 3 is 1 (code segment), a fetch is allowed and a read is allowed only when rights bit 1 is 1. A write always gives fault_o = 3.
- R7: If rights bit 3 is 0 (data segment), a read is allowed and a write is allowed only when rights bit 1 is 1. A fetch always gives fault_o = 3.
- R8: req_kind_i encodes 0 = read, 1 = write, 2 = fetch. Code 3 always gives a type fault on a present segment.
- R9: When several violations apply, the reported fault follows the order not-present first, then type, then limit.
- R10: go_o is high exactly when valid_o is high and fault_o is 0.
- R11: After reset every slot holds an all-zero descriptor, so it reads as not present. A cache write takes effect at the clock edge. A request in the same cycle as the write still sees the old descriptor; a request in a later cycle sees the new one.
- R12: Rights bits 6:5, 2 and 0 have no effect on the translation or on the checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Descriptor cache write enable |
| cfg_seg_i | input | 2 | Slot to write |
| cfg_base_i | input | 24 | Segment base |
| cfg_limit_i | input | 16 | Offset of the last valid byte |
| cfg_rights_i | input | 8 | Rights byte |
| req_valid_i | input | 1 | Access request |
| req_seg_i | input | 2 | Slot used by the access |
| req_off_i | input | 16 | Offset within the segment |
| req_kind_i | input | 2 | 0 read, 1 write, 2 fetch |
| valid_o | output | 1 | A result is present |
| go_o | output | 1 | Memory cycle may proceed |
| paddr_o | output | 24 | Physical address |
| fault_o | output | 2 | 0 none, 1 not present, 2 limit, 3 type |

## Verification
Each request is driven at a falling edge and held for one full cycle. Because every result sits behind a single register stage, the bench reads all four outputs at the next falling edge, which is half a period after the edge that captured them. It then drops the request and checks that the outputs return to idle one cycle later. The same-cycle write case drives a cache write and a request together and expects the result computed from the old descriptor. A request in the following cycle must then see the new descriptor.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  parameter int unsigned PADDR_W  = 24;
  parameter int unsigned OFF_W    = 16;
  parameter int unsigned RIGHTS_W = 8;

  localparam int unsigned RB_PRESENT = 7;
  localparam int unsigned RB_SEGDESC = 4;
  localparam int unsigned RB_EXEC    = 3;
  localparam int unsigned RB_RW      = 1;

  typedef enum logic [1:0] {
    ACC_RD    = 2'd0,
    ACC_WR    = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_LIMIT  = 2'd2,
    FLT_TYPE   = 2'd3
  } fault_e;

  typedef struct packed {
    logic [PADDR_W-1:0]  base;
    logic [OFF_W-1:0]    limit;
    logic [RIGHTS_W-1:0] rights;
  } seg_desc_t;
endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_xlat_pkg::*;
#(
  parameter int unsigned NUM_SEGS = 4,
  localparam int unsigned SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEG_W-1:0] wr_seg_i,
  input  seg_desc_t        wr_desc_i,
  input  logic [SEG_W-1:0] rd_seg_i,
  output seg_desc_t        rd_desc_o
);
  seg_desc_t ent_arr [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_ent
    seg_desc_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q <= '0;
      else if (wr_en_i && (wr_seg_i == SEG_W'(g))) ent_q <= wr_desc_i;
    end
    assign ent_arr[g] = ent_q;
  end

  always_comb begin
    rd_desc_o = '0;
    if (32'(rd_seg_i) < NUM_SEGS) rd_desc_o = ent_arr[rd_seg_i];
  end

  // R11
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (32'(wr_seg_i) < NUM_SEGS)) |=> ent_arr[$past(wr_seg_i)] == $past(wr_desc_i));
endmodule

// File: rtl/seg_rights_chk.sv
module seg_rights_chk
  import seg_xlat_pkg::*;
(
  input  logic [RIGHTS_W-1:0] rights_i,
  input  logic [1:0]          kind_i,
  output logic                present_o,
  output logic                type_ok_o
);
  logic is_code, rw_bit;

  always_comb begin
    present_o = rights_i[RB_PRESENT];
    is_code   = rights_i[RB_EXEC];
    rw_bit    = rights_i[RB_RW];
    type_ok_o = 1'b0;
    if (rights_i[RB_SEGDESC]) begin
      if (is_code) begin
        unique case (acc_kind_e'(kind_i))
          ACC_FETCH: type_ok_o = 1'b1;
          ACC_RD:    type_ok_o = rw_bit;
          default:   type_ok_o = 1'b0;
        endcase
      end else begin
        unique case (acc_kind_e'(kind_i))
          ACC_RD:  type_ok_o = 1'b1;
          ACC_WR:  type_ok_o = rw_bit;
          default: type_ok_o = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_xlat_pkg::*;
(
  input  logic [PADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]   limit_i,
  input  logic [OFF_W-1:0]   off_i,
  output logic [PADDR_W-1:0] paddr_o,
  output logic               in_limit_o
);
  // wraps modulo 2^PADDR_W
  assign paddr_o    = base_i + PADDR_W'(off_i);
  assign in_limit_o = (off_i <= limit_i);
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import seg_xlat_pkg::*;
#(
  parameter int unsigned NUM_SEGS = 4,
  localparam int unsigned SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [SEG_W-1:0]    cfg_seg_i,
  input  logic [PADDR_W-1:0]  cfg_base_i,
  input  logic [OFF_W-1:0]    cfg_limit_i,
  input  logic [RIGHTS_W-1:0] cfg_rights_i,
  input  logic                req_valid_i,
  input  logic [SEG_W-1:0]    req_seg_i,
  input  logic [OFF_W-1:0]    req_off_i,
  input  logic [1:0]          req_kind_i,
  output logic                valid_o,
  output logic                go_o,
  output logic [PADDR_W-1:0]  paddr_o,
  output logic [1:0]          fault_o
);
  seg_desc_t          wr_desc, cur_desc;
  logic               present, type_ok, in_limit;
  logic [PADDR_W-1:0] paddr_raw;
  fault_e             fault_d;

  logic               valid_q, go_q;
  fault_e             fault_q;
  logic [PADDR_W-1:0] paddr_q;

  assign wr_desc = '{base: cfg_base_i, limit: cfg_limit_i, rights: cfg_rights_i};

  seg_desc_cache #(.NUM_SEGS(NUM_SEGS)) u_cache (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cfg_we_i),
    .wr_seg_i  (cfg_seg_i),
    .wr_desc_i (wr_desc),
    .rd_seg_i  (req_seg_i),
    .rd_desc_o (cur_desc)
  );

  seg_rights_chk u_rights (
    .rights_i  (cur_desc.rights),
    .kind_i    (req_kind_i),
    .present_o (present),
    .type_ok_o (type_ok)
  );

  seg_addr_gen u_addr (
    .base_i     (cur_desc.base),
    .limit_i    (cur_desc.limit),
    .off_i      (req_off_i),
    .paddr_o    (paddr_raw),
    .in_limit_o (in_limit)
  );

  // absent > type > limit
  always_comb begin
    if (!present)      fault_d = FLT_ABSENT;
    else if (!type_ok) fault_d = FLT_TYPE;
    else if (!in_limit) fault_d = FLT_LIMIT;
    else               fault_d = FLT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      go_q    <= 1'b0;
      fault_q <= FLT_NONE;
      paddr_q <= '0;
    end else begin
      valid_q <= req_valid_i;
      go_q    <= req_valid_i && (fault_d == FLT_NONE);
      fault_q <= req_valid_i ? fault_d : FLT_NONE;
      paddr_q <= (req_valid_i && (fault_d == FLT_NONE)) ? paddr_raw : '0;
    end
  end

  assign valid_o = valid_q;
  assign go_o    = go_q;
  assign fault_o = fault_q;
  assign paddr_o = paddr_q;

  // R1
  go_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> paddr_o == ($past(cur_desc.base) + PADDR_W'($past(req_off_i))));
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!go_o && fault_o == 2'd0 && paddr_o == '0));
  // R3
  absent_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o == 2'd1) |-> !$past(cur_desc.rights[RB_PRESENT]));
  // R3
  go_present_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> $past(cur_desc.rights[RB_PRESENT]));
  // R4
  go_in_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> ($past(req_off_i) <= $past(cur_desc.limit)));
  // R4
  limit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fault_o == 2'd2) |-> ($past(req_off_i) > $past(cur_desc.limit)));
  // R10
  go_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> (valid_o && fault_o == 2'd0));
endmodule

// File: tb/seg_xlat_test.sv
module seg_xlat_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_seg = '0;
  logic [23:0] cfg_base = '0;
  logic [15:0] cfg_limit = '0;
  logic [7:0]  cfg_rights = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_seg = '0;
  logic [15:0] req_off = '0;
  logic [1:0]  req_kind = '0;
  logic        valid_o, go_o;
  logic [23:0] paddr_o;
  logic [1:0]  fault_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlat uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_seg_i(cfg_seg), .cfg_base_i(cfg_base),
    .cfg_limit_i(cfg_limit), .cfg_rights_i(cfg_rights),
    .req_valid_i(req_valid), .req_seg_i(req_seg), .req_off_i(req_off),
    .req_kind_i(req_kind),
    .valid_o(valid_o), .go_o(go_o), .paddr_o(paddr_o), .fault_o(fault_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Expected result from the requirements: returns fault, address, type-ok flag
  task automatic model(input logic [7:0] r, input logic [23:0] b, input logic [15:0] l,
                       input logic [15:0] o, input logic [1:0] k,
                       output logic [1:0] f, output logic [23:0] a, output logic tok);
    logic [24:0] sum;
    tok = 1'b0;
    if (r[4]) begin
      if (r[3]) tok = (k == 2'd2) || (k == 2'd0 && r[1]);
      else      tok = (k == 2'd0) || (k == 2'd1 && r[1]);
    end
    sum = {1'b0, b} + {9'd0, o};
    a = 24'd0;
    if (!r[7])     f = 2'd1;
    else if (!tok) f = 2'd3;
    else if (o > l) f = 2'd2;
    else begin
      f = 2'd0;
      a = sum[23:0];
    end
  endtask

  task automatic load(logic [1:0] s, logic [23:0] b, logic [15:0] l, logic [7:0] r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = s; cfg_base = b; cfg_limit = l; cfg_rights = r;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xact(string tag, logic [1:0] s, logic [15:0] o, logic [1:0] k,
                      logic [1:0] ef, logic [23:0] ea);
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_off = o; req_kind = k;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "valid", 32'(valid_o), 32'd1);
    chk(tag, "fault", 32'(fault_o), 32'(ef));
    chk(tag, "paddr", 32'(paddr_o), 32'(ea));
    chk("R10", "go", 32'(go_o), 32'(ef == 2'd0));
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk("R2", "idle valid", 32'(valid_o), 32'd0);
    chk("R2", "idle go", 32'(go_o), 32'd0);
    chk("R2", "idle fault", 32'(fault_o), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] bases [4];
    logic [15:0] lims  [4];
    logic [1:0]  f;
    logic [23:0] a;
    logic        tok;
    bases[0] = 24'hFFFF00; lims[0] = 16'h00FF;
    bases[1] = 24'h012345; lims[1] = 16'h0000;
    bases[2] = 24'h000000; lims[2] = 16'hFFFF;
    bases[3] = 24'hABCDEF; lims[3] = 16'h1000;

    repeat (3) @(negedge clk);
    chk("R2", "reset valid", 32'(valid_o), 32'd0);
    chk("R2", "reset go", 32'(go_o), 32'd0);
    chk("R2", "reset fault", 32'(fault_o), 32'd0);
    chk("R2", "reset paddr", 32'(paddr_o), 32'd0);
    rst_n = 1'b1;

    // R11: cleared slots read as absent
    for (int s = 0; s < 4; s++) xact("R11", 2'(s), 16'd0, 2'd0, 2'd1, 24'd0);
    idle_chk();

    // R11: write and request in the same cycle see the old descriptor
    @(negedge clk);
    cfg_we = 1'b1; cfg_seg = 2'd1; cfg_base = 24'h000100; cfg_limit = 16'hFFFF;
    cfg_rights = 8'h92;
    req_valid = 1'b1; req_seg = 2'd1; req_off = 16'h0005; req_kind = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R11", "same-cycle fault", 32'(fault_o), 32'd1);
    xact("R11", 2'd1, 16'h0005, 2'd0, 2'd0, 24'h000105);

    // R12: ignored bits do not change results (code, readable)
    load(2'd2, 24'h001000, 16'h00FF, 8'h9A);
    xact("R12", 2'd2, 16'h0010, 2'd0, 2'd0, 24'h001010);
    load(2'd2, 24'h001000, 16'h00FF, 8'hFF);
    xact("R12", 2'd2, 16'h0010, 2'd0, 2'd0, 24'h001010);
    xact("R12", 2'd2, 16'h0010, 2'd2, 2'd0, 24'h001010);
    xact("R12", 2'd2, 16'h0010, 2'd1, 2'd3, 24'd0);

    // Sweep: every P/S/E/RW combination, boundary offsets, all kinds
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 16; c++) begin
        logic [3:0]  nz;
        logic [7:0]  r;
        logic [15:0] offs [4];
        nz = 4'((c * 7 + s * 3) & 15);
        r = {c[3], nz[1:0], c[2], c[1], nz[2], c[0], nz[3]};
        load(2'(s), bases[s], lims[s], r);
        offs[0] = 16'd0;
        offs[1] = lims[s];
        offs[2] = (lims[s] == 16'hFFFF) ? 16'hFFFE : lims[s] + 16'd1;
        offs[3] = 16'hFFFF;
        for (int oi = 0; oi < 4; oi++) begin
          for (int k = 0; k < 4; k++) begin
            string tag;
            model(r, bases[s], lims[s], offs[oi], 2'(k), f, a, tok);
            if (f == 2'd1)      tag = "R3";
            else if (f == 2'd3) tag = !r[4] ? "R5" : (k == 3) ? "R8" : r[3] ? "R6" : "R7";
            else if (f == 2'd2) tag = "R4";
            else                tag = "R1";
            if ((f == 2'd1 && (!tok || offs[oi] > lims[s])) || (f == 2'd3 && offs[oi] > lims[s]))
              tag = {tag, " R9"};
            tag = {tag, " R12"};
            xact(tag, 2'(s), offs[oi], 2'(k), f, a);
          end
        end
      end
      idle_chk();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule